// File: doc/BRIEF.md
# Element Size Variant Classifier

This block takes a 32-bit vector instruction word and a 4-bit instruction-class code. It returns the variant index that a later stage uses to pick the operand element-size qualifier set, along with a flag that says whether the word is legal for that class. Each class derives the index in its own way:

- from a plain two-bit size field;
- from a size field joined with a merge bit;
- from the lowest or highest set bit of a type-size field;
- from fixed mask tests that pick the smallest element size the word allows.

A code that names no known class is passed through as legal, with index 0.

The decode is one level of logic over the word. The result is captured in an output register, so a class/word pair applied before a rising edge appears on the outputs after that edge. When the flag is low, the index is forced to 0.

Top module: `vclass_variant`

## Requirements
- R1: While rst_n is low, valid_o and variant_o are 0. A result appears on the outputs at the first rising clock edge after its inputs are applied.
- R2: Class codes 0 (no mapping) and 13 to 15 (unassigned), and code 1 (single-variant class), give valid_o=1 and variant_o=0 for any word.
- R3: Class 2 (four sizes) gives valid_o=1 and variant_o equal to word bits [23:22].
- R4: Class 3 (byte/half/single) gives variant_o = word[23:22]. A value of 3 in that field gives valid_o=0.
- R5: Class 4 (half/single/double) gives variant_o = word[23:22] - 1. A value of 0 in that field gives valid_o=0.
- R6: Class 5 (single/double) gives valid_o=1 and variant_o = word[22].
- R7: Class 6 (copy) gives valid_o=1 and variant_o = {word[23:22], word[14]}. Class 7 (move-prefix) gives valid_o=1 and variant_o = {word[23:22], word[16]}.
- R8: Class 8 (predicate merge) gives valid_o=1 and variant_o = word[4].
- R9: Class 9 (index) takes the type-size field word[20:16]. variant_o is the number of trailing zeros in that field, and a zero field gives valid_o=0.
- R10: Class 10 (predicated shift) uses the 4-bit value {word[23:22], word[9:8]}. Class 11 (unpredicated shift) uses {word[23:22], word[20:19]}. variant_o is the bit position of the highest set bit of that value, and a zero value gives valid_o=0.
- R11: Class 12 (logical immediate) always gives valid_o=1. It tests bits 17, 10 and 9 in priority order:
  - bit17=0, bit10=1, bit9=1 gives 0;
  - otherwise bit17=0, bit10=1 gives 1;
  - otherwise bit17=0 gives 2;
  - otherwise 3.
- R12: Whenever valid_o is 0 after reset, variant_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_i | input | 4 | Instruction-class code |
| word_i | input | 32 | Instruction word |
| valid_o | output | 1 | Word is legal for the class |
| variant_o | output | 3 | Element-size variant index |

## Verification
The cases that are rare at the ports are the all-zero type-size fields of the index and shift classes. A uniformly random word makes a zero five-bit index field only once in 32 draws, and a zero four-bit shift value once in 16. The logical-immediate priority chain is a similar corner: its first branch needs three particular bits to line up at once. The stimulus therefore mixes random words with directed words that clear those fields. It also sets every single-bit position of them, and walks all eight combinations of bits 17, 10 and 9.

// File: rtl/vclass_pkg.sv
package vclass_pkg;
    parameter int WORD_W = 32;
    parameter int CLS_W  = 4;
    parameter int VAR_W  = 3;

    // field placement inside the instruction word
    parameter int SIZE_LO   = 22;
    parameter int SIZE_W    = 2;
    parameter int MRG_CPY   = 14;
    parameter int MRG_PFX   = 16;
    parameter int MRG_ZM    = 4;
    parameter int TSZ_LO    = 16;
    parameter int TSZ_W     = 5;
    parameter int TSZL_P_LO = 8;
    parameter int TSZL_U_LO = 19;
    parameter int TSZL_W    = 2;
    parameter int SHF_W     = SIZE_W + TSZL_W;
    parameter int LIMM_N    = 17;
    parameter int LIMM_HI   = 10;
    parameter int LIMM_LO   = 9;

    typedef enum logic [CLS_W-1:0] {
        CLS_PASS    = 4'd0,
        CLS_SINGLE  = 4'd1,
        CLS_SZ4     = 4'd2,
        CLS_SZ_BHS  = 4'd3,
        CLS_SZ_HSD  = 4'd4,
        CLS_SZ_SD   = 4'd5,
        CLS_COPY    = 4'd6,
        CLS_PREFIX  = 4'd7,
        CLS_PMERGE  = 4'd8,
        CLS_INDEX   = 4'd9,
        CLS_SHF_P   = 4'd10,
        CLS_SHF_U   = 4'd11,
        CLS_LOGIMM  = 4'd12
    } vclass_e;

    typedef struct packed {
        logic             ok;
        logic [VAR_W-1:0] idx;
    } vres_t;
endpackage

// File: rtl/vclass_bitpos.sv
// Finds the lowest (HIGH=0) or highest (HIGH=1) set bit of a vector.
module vclass_bitpos #(
    parameter int W     = 5,
    parameter bit HIGH  = 1'b0,
    parameter int POS_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos,
    output logic             none
);
    assign none = ~|vec;

    generate
        if (HIGH) begin : g_top
            always_comb begin
                pos = '0;
                for (int i = 0; i < W; i++) begin
                    if (vec[i]) pos = POS_W'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                pos = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (vec[i]) pos = POS_W'(i);
                end
            end
        end
    endgenerate

    always_comb begin
        if (!none) assert (vec[pos]) else $error("bit position points at a clear bit");
    end
endmodule

// File: rtl/vclass_limm.sv
// Smallest legal element size for the logical-immediate class.
module vclass_limm
    import vclass_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [1:0]        sel
);
    logic n_bit, hi_bit, lo_bit;

    assign n_bit  = word[LIMM_N];
    assign hi_bit = word[LIMM_HI];
    assign lo_bit = word[LIMM_LO];

    always_comb begin
        if (!n_bit && hi_bit && lo_bit) sel = 2'd0;
        else if (!n_bit && hi_bit)      sel = 2'd1;
        else if (!n_bit)                sel = 2'd2;
        else                            sel = 2'd3;
    end
endmodule

// File: rtl/vclass_variant.sv
module vclass_variant
    import vclass_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output logic [VAR_W-1:0]  variant_o
);
    localparam int TZ_W = $clog2(TSZ_W);
    localparam int TB_W = $clog2(SHF_W);

    logic [SIZE_W-1:0] size_f;
    logic [TSZ_W-1:0]  tsz_f;
    logic [SHF_W-1:0]  shf_f;
    logic [TZ_W-1:0]   tz_pos;
    logic [TB_W-1:0]   tb_pos;
    logic              tz_none, tb_none;
    logic [1:0]        limm_sel;
    vres_t             res_d, res_q;

    assign size_f = word_i[SIZE_LO +: SIZE_W];
    assign tsz_f  = word_i[TSZ_LO +: TSZ_W];
    assign shf_f  = (cls_i == CLS_SHF_P) ? {size_f, word_i[TSZL_P_LO +: TSZL_W]}
                                         : {size_f, word_i[TSZL_U_LO +: TSZL_W]};

    vclass_bitpos #(.W(TSZ_W), .HIGH(1'b0), .POS_W(TZ_W)) u_tz (
        .vec (tsz_f),
        .pos (tz_pos),
        .none(tz_none)
    );

    vclass_bitpos #(.W(SHF_W), .HIGH(1'b1), .POS_W(TB_W)) u_tb (
        .vec (shf_f),
        .pos (tb_pos),
        .none(tb_none)
    );

    vclass_limm u_limm (
        .word(word_i),
        .sel (limm_sel)
    );

    always_comb begin
        res_d.ok  = 1'b1;
        res_d.idx = '0;
        case (cls_i)
            CLS_SZ4:    res_d.idx = VAR_W'(size_f);
            CLS_SZ_BHS: begin
                res_d.ok  = (size_f != 2'd3);
                res_d.idx = VAR_W'(size_f);
            end
            CLS_SZ_HSD: begin
                res_d.ok  = (size_f != 2'd0);
                res_d.idx = VAR_W'(size_f - 2'd1);
            end
            CLS_SZ_SD:  res_d.idx = VAR_W'(word_i[SIZE_LO]);
            CLS_COPY:   res_d.idx = VAR_W'({size_f, word_i[MRG_CPY]});
            CLS_PREFIX: res_d.idx = VAR_W'({size_f, word_i[MRG_PFX]});
            CLS_PMERGE: res_d.idx = VAR_W'(word_i[MRG_ZM]);
            CLS_INDEX: begin
                res_d.ok  = !tz_none;
                res_d.idx = VAR_W'(tz_pos);
            end
            CLS_SHF_P, CLS_SHF_U: begin
                res_d.ok  = !tb_none;
                res_d.idx = VAR_W'(tb_pos);
            end
            CLS_LOGIMM: res_d.idx = VAR_W'(limm_sel);
            default:    res_d.idx = '0;
        endcase
        if (!res_d.ok) res_d.idx = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o   = res_q.ok;
    assign variant_o = res_q.idx;

    // ---------------- assertions ----------------
    logic started_q;
    always_ff @(posedge clk) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    AST_BHS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && $past(cls_i) == CLS_SZ_BHS && $past(word_i[SIZE_LO +: SIZE_W]) == 2'd3
        |-> !valid_o) else $error("BHS size 3 accepted"); // R4
    AST_HSD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && $past(cls_i) == CLS_SZ_HSD && $past(word_i[SIZE_LO +: SIZE_W]) != 2'd0
        |-> valid_o && variant_o == VAR_W'($past(word_i[SIZE_LO +: SIZE_W]) - 2'd1))
        else $error("HSD variant wrong"); // R5
    AST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && $past(cls_i) == CLS_INDEX && $past(word_i[TSZ_LO +: TSZ_W]) == '0
        |-> !valid_o) else $error("zero index field accepted"); // R9
    AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && ($past(cls_i) == CLS_SHF_P || $past(cls_i) == CLS_SHF_U)
        |-> variant_o < VAR_W'(SHF_W)) else $error("shift variant out of range"); // R10
    AST_UNKNOWN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && $past(cls_i) > CLS_LOGIMM
        |-> valid_o && variant_o == '0) else $error("unknown class not passed"); // R2
    AST_LIMM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && $past(cls_i) == CLS_LOGIMM
        |-> valid_o && variant_o < VAR_W'(4)) else $error("logical imm variant bad"); // R11
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> variant_o == '0) else $error("invalid with nonzero variant"); // R12
endmodule

// File: tb/vclass_variant_bench.sv
`timescale 1ns/1ps
module vclass_variant_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cls = '0;
    logic [31:0] word = '0;
    logic        valid_o;
    logic [2:0]  variant_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    vclass_variant u_vclass_variant (
        .clk(clk), .rst_n(rst_n), .cls_i(cls), .word_i(word),
        .valid_o(valid_o), .variant_o(variant_o)
    );

    function automatic logic [3:0] ref_model(input logic [3:0] c, input logic [31:0] w);
        logic ok; logic [2:0] v; logic [1:0] sz; logic [3:0] sh;
        ok = 1'b1; v = 3'd0; sz = w[23:22];
        case (c)
            4'd2: v = {1'b0, sz};
            4'd3: begin ok = (sz != 2'd3); v = {1'b0, sz}; end
            4'd4: begin ok = (sz != 2'd0); v = {1'b0, sz} - 3'd1; end
            4'd5: v = {2'b0, w[22]};
            4'd6: v = {sz, w[14]};
            4'd7: v = {sz, w[16]};
            4'd8: v = {2'b0, w[4]};
            4'd9: begin
                if (w[20:16] == 5'd0) ok = 1'b0;
                else begin
                    for (int k = 4; k >= 0; k--) if (w[16+k]) v = 3'(k);
                end
            end
            4'd10, 4'd11: begin
                sh = (c == 4'd10) ? {sz, w[9:8]} : {sz, w[20:19]};
                if (sh == 4'd0) ok = 1'b0;
                else begin
                    for (int k = 0; k < 4; k++) if (sh[k]) v = 3'(k);
                end
            end
            4'd12: begin
                if (!w[17] && w[10] && w[9]) v = 3'd0;
                else if (!w[17] && w[10])    v = 3'd1;
                else if (!w[17])             v = 3'd2;
                else                         v = 3'd3;
            end
            default: v = 3'd0;
        endcase
        if (!ok) v = 3'd0;
        return {ok, v};
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            4'd10, 4'd11: return "R10";
            4'd12: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic [31:0] w);
        logic [3:0] exp;
        @(negedge clk);
        cls = c; word = w;
        @(negedge clk);
        exp = ref_model(c, w);
        n_run++;
        if ({valid_o, variant_o} !== exp) begin
            n_fail++;
            $display("FAIL %s cls=%0d word=%h actual valid=%0b var=%0d expected valid=%0b var=%0d",
                     req_of(c), c, w, valid_o, variant_o, exp[3], exp[2:0]);
        end
        n_run++;   // R12: invalid result carries index 0
        if (!valid_o && variant_o != 3'd0) begin
            n_fail++;
            $display("FAIL R12 actual var=%0d expected 0", variant_o);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        cls = 4'd2; word = 32'h00C0_0000;
        @(negedge clk);
        n_run++;   // R1 reset state
        if (valid_o !== 1'b0 || variant_o !== 3'd0) begin
            n_fail++;
            $display("FAIL R1 reset actual valid=%0b var=%0d expected 0 0", valid_o, variant_o);
        end
        rst_n = 1'b1;
        // R1 latency: output follows input after one edge
        apply(4'd2, 32'h00C0_0000);
        // directed: size corners (R4, R5)
        for (int s = 0; s < 4; s++) begin
            apply(4'd3, 32'(s) << 22);
            apply(4'd4, 32'(s) << 22);
        end
        // directed: zero and single-bit type-size fields (R9, R10)
        apply(4'd9, 32'hFFE0_FFFF);
        for (int k = 0; k < 5; k++) apply(4'd9, 32'h1 << (16 + k));
        apply(4'd10, 32'hFF3F_FCFF);
        apply(4'd11, 32'hFF27_FFFF);
        for (int k = 0; k < 2; k++) begin
            apply(4'd10, 32'h1 << (8 + k));
            apply(4'd10, 32'h1 << (22 + k));
            apply(4'd11, 32'h1 << (19 + k));
        end
        // directed: all bit17/10/9 combinations (R11)
        for (int m = 0; m < 8; m++)
            apply(4'd12, (m[2] ? 32'h20000 : 0) | (m[1] ? 32'h400 : 0) | (m[0] ? 32'h200 : 0));
        // random words for every class code
        for (int c = 0; c < 16; c++)
            for (int n = 0; n < 250; n++) apply(4'(c), $urandom);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule